// File: doc/BRIEF.md
# Serial Flash Page-Program Slave

This block is the device end of a serial flash link. It watches a serial clock, an active-low chip select and a serial data line, all driven synchronously to the system clock, and it decodes three commands: write enable, read status and page program. A page-program command carries a 24-bit address followed by data bytes. The data bytes are gathered in a 256-byte staging buffer and committed to a small on-chip memory array once chip select rises cleanly. While that commit and the self-timed busy period that follows it run, the status register reports the device as busy.

The command frame is decoded by a state machine with states F_OPC (await opcode), F_WREN (write enable received, waiting for a clean end), F_ADDR (collecting address bytes), F_DATA (collecting data bytes), F_STAT (returning status) and F_SKIP (discarding the rest of the frame). Transitions: F_OPC to F_ADDR on an accepted program opcode, to F_WREN on write enable while idle, to F_STAT on read status and to F_SKIP otherwise. F_WREN moves to F_SKIP on any further byte. F_ADDR moves to F_DATA after the third address byte. Any state returns to F_OPC when chip select is high. The program engine has states E_IDLE, E_PROG (walks the 256 buffer offsets and writes the marked ones) and E_HOLD (counts the busy delay). It moves from E_IDLE to E_PROG on a commit pulse, from E_PROG to E_HOLD after offset 255, and from E_HOLD to E_IDLE when the delay count ends.

Top module: `spf_pp_slave`

## Requirements
- R1: After reset the status byte reads 0x00, the serial output is 0, and every array byte reads 0xFF.
- R2: Opcode 0x06 followed by chip select rising on a byte boundary sets the write-enable bit (status bit 1); if extra bits follow the opcode, or the device is busy, the bit is not set.
- R3: Opcode 0x05 returns the status byte most significant bit first on each following byte, with bit 0 = write in progress and bit 1 = write enable; the output is 0 whenever chip select is high.
- R4: Opcode 0x02 sent while the write-enable bit is 0 changes no array byte and does not start a busy period.
- R5: An accepted page program (opcode 0x02, three address bytes, data bytes) writes each data byte to the page given by address bits [8 +: page bits] at the offset given by address bits [7:0], incrementing per byte; higher address bits are ignored.
- R6: Data past offset 255 wraps to offset 0 of the same page and never reaches the next page.
- R7: When more than 256 data bytes arrive, only the last 256 are written; earlier bytes at the same offset are replaced.
- R8: Bytes of the page that received no data keep their contents.
- R9: If chip select rises within a byte, or before any data byte, nothing is written, no busy period starts and the write-enable bit keeps its value.
- R10: An accepted page program clears the write-enable bit at the start of the busy period.
- R11: Write in progress reads 1 from the commit until 256 + BUSY_CYCLES clocks later, then 0.
- R12: Programming combines data with the stored byte by bitwise AND, so bits only go from 1 to 0.
- R13: Write-enable and page-program commands received while write in progress is 1 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| spi_sck | input | 1 | Serial clock, sampled on its rising edge |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data into the device |
| spi_miso | output | 1 | Serial status data out of the device |
| arr_raddr | input | ADDR_W | Array observation address |
| arr_rdata | output | 8 | Array byte at arr_raddr |

## Verification
The bench attacks the frame edges: a write enable with a trailing bit, a program cut off mid-byte and a program with no data must all leave the array and status untouched, whereas a design that commits on any chip-select rise would write garbage and turn busy. A program starting two bytes before a page end checks the wrap, which a design that carries the offset into the page number would spill into the next page. A 258-byte burst checks that the two earliest bytes are replaced rather than ANDed into the array, and repeated writes to one byte check that stored zeros survive a later write of ones.

// File: rtl/spf_pkg.sv
package spf_pkg;
    localparam int BYTE_W = 8;

    localparam logic [BYTE_W-1:0] OP_PROG   = 8'h02;
    localparam logic [BYTE_W-1:0] OP_STATUS = 8'h05;
    localparam logic [BYTE_W-1:0] OP_WEN    = 8'h06;

    localparam int ST_WIP = 0;
    localparam int ST_WEL = 1;

    typedef enum logic [2:0] {
        F_OPC,
        F_WREN,
        F_ADDR,
        F_DATA,
        F_STAT,
        F_SKIP
    } frame_t;

    typedef enum logic [1:0] {
        E_IDLE,
        E_PROG,
        E_HOLD
    } eng_t;
endpackage

// File: rtl/spf_shift_rx.sv
module spf_shift_rx
    import spf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sck_rise,
    input  logic              mosi,
    output logic              byte_stb,
    output logic [BYTE_W-1:0] byte_val,
    output logic [2:0]        bit_idx
);
    logic [BYTE_W-1:0] shreg;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg    <= '0;
            bit_idx  <= '0;
            byte_stb <= 1'b0;
            byte_val <= '0;
        end else begin
            byte_stb <= 1'b0;
            if (cs_n) begin
                bit_idx <= '0;
            end else if (sck_rise) begin
                shreg   <= {shreg[BYTE_W-2:0], mosi};
                bit_idx <= bit_idx + 3'd1;
                if (bit_idx == 3'd7) begin
                    byte_stb <= 1'b1;
                    byte_val <= {shreg[BYTE_W-2:0], mosi};
                end
            end
        end
    end
endmodule

// File: rtl/spf_page_buf.sv
module spf_page_buf
    import spf_pkg::*;
#(
    parameter int PAGE_BYTES = 256,
    localparam int OFF_W = $clog2(PAGE_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              wr_en,
    input  logic [OFF_W-1:0]  wr_off,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [OFF_W-1:0]  rd_off,
    output logic [BYTE_W-1:0] rd_data,
    output logic              rd_valid
);
    logic [BYTE_W-1:0]     data_q [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] valid_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else if (clr) begin
            valid_q <= '0;
        end else if (wr_en) begin
            valid_q[wr_off] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            data_q[wr_off] <= wr_data;
        end
    end

    assign rd_data  = data_q[rd_off];
    assign rd_valid = valid_q[rd_off];
endmodule

// File: rtl/spf_prog_engine.sv
module spf_prog_engine
    import spf_pkg::*;
#(
    parameter int PAGE_BYTES  = 256,
    parameter int NUM_PAGES   = 4,
    parameter int BUSY_CYCLES = 64,
    localparam int OFF_W  = $clog2(PAGE_BYTES),
    localparam int PG_W   = $clog2(NUM_PAGES),
    localparam int ADDR_W = OFF_W + PG_W,
    localparam int TOTAL  = PAGE_BYTES * NUM_PAGES,
    localparam int HC_W   = $clog2(BUSY_CYCLES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic [PG_W-1:0]   go_page,
    output logic [OFF_W-1:0]  buf_off,
    input  logic [BYTE_W-1:0] buf_data,
    input  logic              buf_valid,
    output logic              busy,
    input  logic [ADDR_W-1:0] arr_raddr,
    output logic [BYTE_W-1:0] arr_rdata
);
    eng_t              state, nxt;
    logic [OFF_W-1:0]  idx;
    logic [PG_W-1:0]   page_q;
    logic [HC_W-1:0]   hold_cnt;
    logic [BYTE_W-1:0] mem [TOTAL];

    always_ff @(posedge clk) begin
        if (!rst_n) state <= E_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            E_IDLE: if (go) nxt = E_PROG;
            E_PROG: if (idx == OFF_W'(PAGE_BYTES - 1)) nxt = E_HOLD;
            E_HOLD: if (hold_cnt == HC_W'(BUSY_CYCLES - 1)) nxt = E_IDLE;
            default: nxt = E_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx      <= '0;
            page_q   <= '0;
            hold_cnt <= '0;
        end else begin
            unique case (state)
                E_IDLE: begin
                    idx      <= '0;
                    hold_cnt <= '0;
                    if (go) page_q <= go_page;
                end
                E_PROG: idx <= idx + OFF_W'(1);
                E_HOLD: hold_cnt <= hold_cnt + HC_W'(1);
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < TOTAL; i++) mem[i] <= '1;
        end else if (state == E_PROG && buf_valid) begin
            mem[{page_q, idx}] <= mem[{page_q, idx}] & buf_data;
        end
    end

    assign buf_off   = idx;
    assign busy      = (state != E_IDLE);
    assign arr_rdata = mem[arr_raddr];
endmodule

// File: rtl/spf_pp_slave.sv
module spf_pp_slave
    import spf_pkg::*;
#(
    parameter int NUM_PAGES   = 4,
    parameter int BUSY_CYCLES = 64,
    localparam int PAGE_BYTES = 256,
    localparam int OFF_W  = $clog2(PAGE_BYTES),
    localparam int PG_W   = $clog2(NUM_PAGES),
    localparam int ADDR_W = OFF_W + PG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_sck,
    input  logic              spi_cs_n,
    input  logic              spi_mosi,
    output logic              spi_miso,
    input  logic [ADDR_W-1:0] arr_raddr,
    output logic [7:0]        arr_rdata
);
    frame_t            state, nxt;
    logic              sck_q, cs_q;
    logic              sck_rise, cs_rise;
    logic              byte_stb;
    logic [BYTE_W-1:0] byte_val;
    logic [2:0]        bit_idx;
    logic [1:0]        addr_cnt;
    logic [PG_W-1:0]   page_q;
    logic [OFF_W-1:0]  off_q;
    logic              got_data;
    logic              wel;
    logic              busy;
    logic              prog_go;
    logic              buf_clr, buf_wr;
    logic [OFF_W-1:0]  eng_off;
    logic [BYTE_W-1:0] eng_data;
    logic              eng_valid;
    logic [BYTE_W-1:0] status_byte;
    logic              accept_prog, commit_now;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_q <= 1'b0;
            cs_q  <= 1'b1;
        end else begin
            sck_q <= spi_sck;
            cs_q  <= spi_cs_n;
        end
    end

    assign sck_rise = spi_sck & ~sck_q;
    assign cs_rise  = spi_cs_n & ~cs_q;

    spf_shift_rx u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_n     (spi_cs_n),
        .sck_rise (sck_rise),
        .mosi     (spi_mosi),
        .byte_stb (byte_stb),
        .byte_val (byte_val),
        .bit_idx  (bit_idx)
    );

    assign accept_prog = (state == F_OPC) && byte_stb && (byte_val == OP_PROG) && wel && !busy;
    assign commit_now  = cs_rise && (state == F_DATA) && got_data && (bit_idx == 3'd0);
    assign buf_clr     = accept_prog;
    assign buf_wr      = (state == F_DATA) && byte_stb && !spi_cs_n;

    // frame state register
    always_ff @(posedge clk) begin
        if (!rst_n)        state <= F_OPC;
        else if (spi_cs_n) state <= F_OPC;
        else               state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            F_OPC: begin
                if (byte_stb) begin
                    if (accept_prog)                          nxt = F_ADDR;
                    else if (byte_val == OP_WEN && !busy)     nxt = F_WREN;
                    else if (byte_val == OP_STATUS)           nxt = F_STAT;
                    else                                      nxt = F_SKIP;
                end
            end
            F_WREN: if (byte_stb) nxt = F_SKIP;
            F_ADDR: if (byte_stb && addr_cnt == 2'd2) nxt = F_DATA;
            F_DATA: nxt = F_DATA;
            F_STAT: nxt = F_STAT;
            F_SKIP: nxt = F_SKIP;
            default: nxt = F_SKIP;
        endcase
    end

    // frame outputs and datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_cnt <= '0;
            page_q   <= '0;
            off_q    <= '0;
            got_data <= 1'b0;
            wel      <= 1'b0;
            prog_go  <= 1'b0;
        end else begin
            prog_go <= commit_now;
            if (commit_now) begin
                wel <= 1'b0;
            end else if (cs_rise && state == F_WREN && bit_idx == 3'd0 && !busy) begin
                wel <= 1'b1;
            end
            unique case (state)
                F_OPC: begin
                    addr_cnt <= '0;
                    got_data <= 1'b0;
                end
                F_ADDR: begin
                    if (byte_stb) begin
                        addr_cnt <= addr_cnt + 2'd1;
                        if (addr_cnt == 2'd1) page_q <= byte_val[PG_W-1:0];
                        if (addr_cnt == 2'd2) off_q  <= byte_val[OFF_W-1:0];
                    end
                end
                F_DATA: begin
                    if (buf_wr) begin
                        off_q    <= off_q + OFF_W'(1);
                        got_data <= 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    spf_page_buf #(.PAGE_BYTES(PAGE_BYTES)) u_buf (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (buf_clr),
        .wr_en    (buf_wr),
        .wr_off   (off_q),
        .wr_data  (byte_val),
        .rd_off   (eng_off),
        .rd_data  (eng_data),
        .rd_valid (eng_valid)
    );

    spf_prog_engine #(
        .PAGE_BYTES  (PAGE_BYTES),
        .NUM_PAGES   (NUM_PAGES),
        .BUSY_CYCLES (BUSY_CYCLES)
    ) u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (prog_go),
        .go_page   (page_q),
        .buf_off   (eng_off),
        .buf_data  (eng_data),
        .buf_valid (eng_valid),
        .busy      (busy),
        .arr_raddr (arr_raddr),
        .arr_rdata (arr_rdata)
    );

    always_comb begin
        status_byte         = '0;
        status_byte[ST_WIP] = busy;
        status_byte[ST_WEL] = wel;
    end

    assign spi_miso = (state == F_STAT) ? status_byte[3'd7 - bit_idx] : 1'b0;
endmodule

// File: rtl/spf_pp_checker.sv
module spf_pp_checker #(
    parameter int ADDR_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              spi_cs_n,
    input logic              spi_miso,
    input logic              go,
    input logic              wip,
    input logic              wel,
    input logic [ADDR_W-1:0] arr_raddr,
    input logic [7:0]        arr_rdata
);
    assert_wip_after_go_R11: assert property (@(posedge clk) disable iff (!rst_n)
        go |=> wip);

    assert_wel_dropped_R10: assert property (@(posedge clk) disable iff (!rst_n)
        go |=> !wel);

    assert_wip_needs_go_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!wip && !go) |=> !wip);

    assert_no_go_while_busy_R13: assert property (@(posedge clk) disable iff (!rst_n)
        wip |-> !go);

    assert_miso_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_cs_n && $past(spi_cs_n)) |-> !spi_miso);

    assert_bits_only_clear_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(arr_raddr) |-> ((arr_rdata & ~$past(arr_rdata)) == 8'h00));
endmodule

bind spf_pp_slave spf_pp_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .spi_cs_n  (spi_cs_n),
    .spi_miso  (spi_miso),
    .go        (prog_go),
    .wip       (busy),
    .wel       (wel),
    .arr_raddr (arr_raddr),
    .arr_rdata (arr_rdata)
);

// File: tb/test_spf_pp_slave.sv
module test_spf_pp_slave;
    localparam int ADDR_W = 10;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              spi_sck = 1'b0;
    logic              spi_cs_n = 1'b1;
    logic              spi_mosi = 1'b0;
    logic              spi_miso;
    logic [ADDR_W-1:0] arr_raddr = '0;
    logic [7:0]        arr_rdata;

    int total = 0;
    int bad = 0;
    logic [7:0] pdata [300];

    // {address, data byte, expected array byte}
    localparam logic [39:0] VEC [6] = '{
        {24'h000010, 8'hA5, 8'hA5},
        {24'h000010, 8'h3C, 8'h24},
        {24'h0001FF, 8'h12, 8'h12},
        {24'h000080, 8'h00, 8'h00},
        {24'h000100, 8'hF0, 8'hF0},
        {24'hFF0210, 8'h81, 8'h81}
    };

    always #10 clk = ~clk;

    spf_pp_slave i_spf_pp_slave (
        .clk       (clk),
        .rst_n     (rst_n),
        .spi_sck   (spi_sck),
        .spi_cs_n  (spi_cs_n),
        .spi_mosi  (spi_mosi),
        .spi_miso  (spi_miso),
        .arr_raddr (arr_raddr),
        .arr_rdata (arr_rdata)
    );

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %02h expected %02h", tag, got, exp);
        end
    endtask

    task automatic spi_bits(input logic [7:0] tx, input int n, output logic [7:0] rx);
        rx = '0;
        for (int b = 0; b < n; b++) begin
            @(negedge clk) spi_mosi = tx[7-b];
            @(negedge clk);
            rx = {rx[6:0], spi_miso};
            spi_sck = 1'b1;
            @(negedge clk);
            @(negedge clk) spi_sck = 1'b0;
        end
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic cs_low();
        @(negedge clk) spi_cs_n = 1'b0;
        @(negedge clk);
    endtask

    task automatic cs_high();
        @(negedge clk) spi_cs_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic send_wen(input int extra);
        logic [7:0] d;
        cs_low();
        spi_bits(8'h06, 8, d);
        if (extra > 0) spi_bits(8'h00, extra, d);
        cs_high();
    endtask

    task automatic read_status(output logic [7:0] st);
        logic [7:0] d;
        cs_low();
        spi_bits(8'h05, 8, d);
        spi_bits(8'h00, 8, st);
        cs_high();
    endtask

    task automatic prog(input logic [23:0] a, input int n, input int extra);
        logic [7:0] d;
        cs_low();
        spi_bits(8'h02, 8, d);
        spi_bits(a[23:16], 8, d);
        spi_bits(a[15:8], 8, d);
        spi_bits(a[7:0], 8, d);
        for (int i = 0; i < n; i++) spi_bits(pdata[i], 8, d);
        if (extra > 0) spi_bits(8'hFF, extra, d);
        cs_high();
    endtask

    task automatic wait_ready();
        logic [7:0] st;
        for (int i = 0; i < 40; i++) begin
            read_status(st);
            if (st[0] == 1'b0) break;
        end
    endtask

    task automatic peek(input int a, output logic [7:0] v);
        @(negedge clk) arr_raddr = ADDR_W'(a);
        #1 v = arr_rdata;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] st, v;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1 reset state
        chk("R1 miso idle", {7'b0, spi_miso}, 8'h00);
        peek(0, v);     chk("R1 array low", v, 8'hFF);
        peek(1023, v);  chk("R1 array high", v, 8'hFF);
        read_status(st); chk("R1 status", st, 8'h00);

        // R4 program without write enable
        pdata[0] = 8'h00;
        prog(24'h000020, 1, 0);
        read_status(st); chk("R4 no busy", st, 8'h00);
        peek(32'h20, v); chk("R4 array unchanged", v, 8'hFF);

        // R2 write enable with a trailing bit, then a clean one; R3 status bits
        send_wen(1);
        read_status(st); chk("R2 trailing bit ignored", st, 8'h00);
        send_wen(0);
        read_status(st); chk("R2 R3 wel set", st, 8'h02);
        read_status(st); chk("R3 status repeat", st, 8'h02);

        // R5 R12 R10 R11 vector walk
        for (int k = 0; k < 6; k++) begin
            send_wen(0);
            pdata[0] = VEC[k][15:8];
            prog(VEC[k][39:16], 1, 0);
            read_status(st); chk("R10 R11 busy, wel cleared", st, 8'h01);
            wait_ready();
            read_status(st); chk("R11 ready", st, 8'h00);
            peek(int'(VEC[k][25:16]), v); chk("R5 R12 array byte", v, VEC[k][7:0]);
        end

        // R13 write enable while busy is ignored
        send_wen(0);
        pdata[0] = 8'h11;
        prog(24'h000040, 1, 0);
        send_wen(0);
        wait_ready();
        read_status(st); chk("R13 wen while busy", st, 8'h00);
        peek(32'h40, v); chk("R5 single write", v, 8'h11);

        // R9 dropped frames keep wel and write nothing
        send_wen(0);
        pdata[0] = 8'h00; pdata[1] = 8'h00;
        prog(24'h000050, 2, 3);
        read_status(st); chk("R9 mid-byte end", st, 8'h02);
        peek(32'h50, v); chk("R9 array untouched", v, 8'hFF);
        prog(24'h000060, 0, 0);
        read_status(st); chk("R9 no data", st, 8'h02);
        peek(32'h60, v); chk("R9 array untouched 2", v, 8'hFF);

        // R6 R8 wrap inside page 2
        pdata[0] = 8'h11; pdata[1] = 8'h22; pdata[2] = 8'h33; pdata[3] = 8'h44;
        prog(24'h0002FE, 4, 0);
        wait_ready();
        peek(32'h2FE, v); chk("R6 offset FE", v, 8'h11);
        peek(32'h2FF, v); chk("R6 offset FF", v, 8'h22);
        peek(32'h200, v); chk("R6 wrapped 00", v, 8'h33);
        peek(32'h201, v); chk("R6 wrapped 01", v, 8'h44);
        peek(32'h300, v); chk("R6 no spill", v, 8'hFF);
        peek(32'h210, v); chk("R8 other byte kept", v, 8'h81);
        peek(32'h202, v); chk("R8 unwritten byte", v, 8'hFF);

        // R7 258 bytes into page 3
        for (int i = 0; i < 258; i++) pdata[i] = 8'(i) ^ ((i >= 256) ? 8'h5A : 8'h00);
        send_wen(0);
        prog(24'h000300, 258, 0);
        wait_ready();
        peek(32'h300, v); chk("R7 last replaces 0", v, 8'h5A);
        peek(32'h301, v); chk("R7 last replaces 1", v, 8'h5B);
        peek(32'h302, v); chk("R7 offset 2", v, 8'h02);
        peek(32'h3C8, v); chk("R7 offset C8", v, 8'hC8);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule